// File: doc/BRIEF.md
# Flat Page-Table MMU with Translation Cache

This block turns 32-bit device virtual addresses into 36-bit physical bus addresses. It uses one flat table in memory that holds one 32-bit entry per 4KB virtual page. An entry may instead describe a page of 64KB or 1MB. In that case every entry of the aligned region carries the same size flag, so any one of them can stand for the whole region. Recent translations are held in a small fully associative cache. On a miss, the block stalls, fetches one entry through its table read port, fills the cache and then answers.

Each answer carries a fault code. A fault arises when the entry is not valid, when a write meets a read-only page, or when the resulting frame lies at or above a frame cap. Each fault class has its own abort enable and interrupt enable. When a scratch page is enabled, a faulting access is steered to that page instead of its computed address. A clear request invalidates the whole cache. A busy flag stays high until the clear is finished.

Top module: `flat_mmu`

## Requirements
- R1: After reset, rsp_valid, pt_rd_req and tlb_clearing are low, and req_ready is high.
- R2: While mmu_en is low, an accepted request is answered in the cycle after acceptance. The answer has rsp_pa equal to the zero-extended virtual address and fault code 0, and no table read is made.
- R3: A cache miss makes exactly one table read. pt_rd_req is high for one cycle, and pt_rd_addr equals table_frame*4096 + 4*VA[31:12]. The answer appears in the cycle after pt_rd_valid.
- R4: Entry layout is as follows. Bits 23:0 hold the frame, bit 28 is valid and bit 29 is writable. For a 4KB page, rsp_pa = {frame, VA[11:0]}.
- R5: Entry bit 30 marks a 64KB page, with rsp_pa = {frame[23:4], VA[15:0]}. Entry bit 31 marks a 1MB page, with rsp_pa = {frame[23:8], VA[19:0]}, and bit 31 takes precedence over bit 30. Once one entry of such a region is cached, any page in that region hits.
- R6: A cache hit makes no table read and is answered in the cycle after acceptance.
- R7: rsp_fault codes are 0 (none), 1 (entry invalid), 2 (write to a non-writable page) and 3 (result frame >= cap_frames). Priority runs 1, then 2, then 3. Invalid entries are not cached, so a repeat access walks again.
- R8: fault_policy bit 2*(code-1) enables rsp_abort for that code, and bit 2*(code-1)+1 enables irq_pulse. Both outputs are valid only alongside rsp_valid.
- R9: With scratch_en high, a faulting answer has rsp_pa = {scratch_frame, VA[11:0]}.
- R10: A tlb_clear pulse raises tlb_clearing in the next cycle. The flag holds req_ready low and falls within TLB_N+3 cycles. Afterwards, every earlier translation misses.
- R11: A clear that arrives during a walk lets the walk finish with a correct answer, then clears. The walked page misses afterwards.
- R12: Fills use round-robin slots, starting at slot 0 after reset or after a clear. The (TLB_N+1)-th distinct page evicts the first one filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mmu_en | input | 1 | Translation enable; low means pass-through |
| table_frame | input | 24 | Frame number of the page table base |
| cap_frames | input | 24 | First physical frame that is out of bounds |
| scratch_frame | input | 24 | Frame of the redirect page |
| scratch_en | input | 1 | Redirect faulting accesses |
| fault_policy | input | 6 | Abort/interrupt enable pair per fault code |
| tlb_clear | input | 1 | Pulse to invalidate the cache |
| tlb_clearing | output | 1 | Clear pending or in progress |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Answer valid (one cycle) |
| rsp_pa | output | 36 | Physical address |
| rsp_fault | output | 2 | Fault code |
| rsp_abort | output | 1 | Abort for this answer |
| irq_pulse | output | 1 | Interrupt for this answer |
| pt_rd_req | output | 1 | Table entry read strobe |
| pt_rd_addr | output | 36 | Byte address of the entry |
| pt_rd_valid | input | 1 | Read data valid |
| pt_rd_data | input | 32 | Table entry |

## Verification
A cache clear and the completion of a table walk can land together. The clear asks for every slot to be invalidated, while the walk wants to write one slot. The bench provokes this by slowing its memory responder and pulsing tlb_clear while the read is outstanding. It judges the result on two counts: the pending answer must still be correct, and a repeat of the same page must cost a fresh table read. A clear pulse given in the same cycle as the read data is covered as well, because the sweep that follows removes the slot that was just written.

// File: rtl/flat_mmu.sv
module flat_mmu #(
  parameter int TLB_N   = 8,
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmu_en,
  input  logic [FRAME_W-1:0] table_frame,
  input  logic [FRAME_W-1:0] cap_frames,
  input  logic [FRAME_W-1:0] scratch_frame,
  input  logic               scratch_en,
  input  logic [5:0]         fault_policy,
  input  logic               tlb_clear,
  output logic               tlb_clearing,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_va,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic [FRAME_W+11:0] rsp_pa,
  output logic [1:0]         rsp_fault,
  output logic               rsp_abort,
  output logic               irq_pulse,
  output logic               pt_rd_req,
  output logic [FRAME_W+11:0] pt_rd_addr,
  input  logic               pt_rd_valid,
  input  logic [31:0]        pt_rd_data
);
  localparam int IW   = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int PA_W = FRAME_W + 12;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [TLB_N-1:0]   t_vld;
  logic [TLB_N-1:0]   t_w;
  logic [19:0]        t_vpn [TLB_N];
  logic [1:0]         t_sz  [TLB_N];
  logic [FRAME_W-1:0] t_frm [TLB_N];
  logic [IW-1:0]      rr, clr_idx;
  logic               clr_pend, clr_busy;
  logic [31:0]        w_va;
  logic               w_wr;

  function automatic logic vmatch(logic [19:0] a, logic [19:0] b, logic [1:0] sz);
    logic [19:0] m;
    m = (sz == 2'd2) ? 20'hFFF00 : (sz == 2'd1) ? 20'hFFFF0 : 20'hFFFFF;
    return ((a ^ b) & m) == 20'h0;
  endfunction

  function automatic logic [PA_W+1:0] xlate(logic vld, logic w, logic [1:0] sz,
                                            logic [FRAME_W-1:0] frm, logic [31:0] va,
                                            logic wr);
    logic [PA_W-1:0] pa;
    logic [1:0] code;
    case (sz)
      2'd2:    pa = {frm[FRAME_W-1:8], va[19:0]};
      2'd1:    pa = {frm[FRAME_W-1:4], va[15:0]};
      default: pa = {frm, va[11:0]};
    endcase
    if (!vld)                           code = 2'd1;
    else if (wr && !w)                  code = 2'd2;
    else if (pa[PA_W-1:12] >= cap_frames) code = 2'd3;
    else                                code = 2'd0;
    if (code != 2'd0 && scratch_en) pa = {scratch_frame, va[11:0]};
    return {code, pa};
  endfunction

  function automatic logic pol_bit(logic [1:0] c, logic irq);
    case (c)
      2'd1:    return irq ? fault_policy[1] : fault_policy[0];
      2'd2:    return irq ? fault_policy[3] : fault_policy[2];
      2'd3:    return irq ? fault_policy[5] : fault_policy[4];
      default: return 1'b0;
    endcase
  endfunction

  logic          hit;
  logic [IW-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (t_vld[i] && vmatch(t_vpn[i], req_va[31:12], t_sz[i])) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
  end

  logic [1:0]      psz;
  logic [PA_W+1:0] hit_res, walk_res, res;
  logic            accept, emit, fill;
  logic            unused_pte;

  assign psz          = pt_rd_data[31] ? 2'd2 : (pt_rd_data[30] ? 2'd1 : 2'd0);
  assign unused_pte   = ^pt_rd_data[27:FRAME_W];
  assign hit_res      = xlate(1'b1, t_w[hit_idx], t_sz[hit_idx], t_frm[hit_idx], req_va, req_write);
  assign walk_res     = xlate(pt_rd_data[28], pt_rd_data[29], psz, pt_rd_data[FRAME_W-1:0], w_va, w_wr);
  assign res          = (st == S_WAIT) ? walk_res : hit_res;
  assign tlb_clearing = clr_pend | clr_busy;
  assign req_ready    = (st == S_IDLE) && !tlb_clearing;
  assign accept       = req_valid && req_ready;
  assign emit         = (st == S_WAIT) ? pt_rd_valid : (accept && mmu_en && hit);
  assign fill         = (st == S_WAIT) && pt_rd_valid && pt_rd_data[28] && !clr_pend;
  assign pt_rd_req    = (st == S_REQ);
  assign pt_rd_addr   = {table_frame, 12'h000} + PA_W'({w_va[31:12], 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      t_vld     <= '0;
      rr        <= '0;
      clr_idx   <= '0;
      clr_pend  <= 1'b0;
      clr_busy  <= 1'b0;
      w_va      <= '0;
      w_wr      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
      rsp_abort <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      rsp_valid <= emit || (accept && !mmu_en);
      rsp_abort <= emit && pol_bit(res[PA_W+1:PA_W], 1'b0);
      irq_pulse <= emit && pol_bit(res[PA_W+1:PA_W], 1'b1);
      if (accept && !mmu_en) begin
        rsp_pa    <= PA_W'(req_va);
        rsp_fault <= 2'd0;
      end else if (emit) begin
        rsp_pa    <= res[PA_W-1:0];
        rsp_fault <= res[PA_W+1:PA_W];
      end

      case (st)
        S_IDLE:
          if (accept && mmu_en && !hit) begin
            w_va <= req_va;
            w_wr <= req_write;
            st   <= S_REQ;
          end else if (clr_pend && !clr_busy) begin
            clr_busy <= 1'b1;
            clr_idx  <= '0;
            rr       <= '0;
            clr_pend <= 1'b0;
          end
        S_REQ: st <= S_WAIT;
        S_WAIT:
          if (pt_rd_valid) begin
            st <= S_IDLE;
            if (fill) begin
              t_vld[rr] <= 1'b1;
              rr <= (rr == IW'(TLB_N - 1)) ? '0 : rr + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase

      if (clr_busy) begin
        t_vld[clr_idx] <= 1'b0;
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == IW'(TLB_N - 1)) clr_busy <= 1'b0;
      end
      if (tlb_clear) clr_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      t_vpn[rr] <= w_va[31:12];
      t_sz[rr]  <= psz;
      t_w[rr]   <= pt_rd_data[29];
      t_frm[rr] <= pt_rd_data[FRAME_W-1:0];
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !rsp_valid && !pt_rd_req);

  assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mmu_en) |=> rsp_valid && rsp_fault == 2'd0 && rsp_pa == PA_W'($past(req_va)));

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_req |=> !pt_rd_req);

  assert_walk_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && pt_rd_valid) |=> rsp_valid);

  assert_abort_needs_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_abort || irq_pulse) |-> rsp_valid && rsp_fault != 2'd0);

  assert_clear_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_clear |=> tlb_clearing && !req_ready);

  assert_sweep_after_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> st == S_IDLE);

  assert_fill_one_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> $countones(t_vld) >= 1);
endmodule

// File: tb/sim_flat_mmu.sv
module sim_flat_mmu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mmu_en = 1'b0;
  logic [23:0] table_frame = 24'h012340;
  logic [23:0] cap_frames = 24'hFFFFFF;
  logic [23:0] scratch_frame = 24'hABCDEF;
  logic scratch_en = 1'b0;
  logic [5:0] fault_policy = 6'b000000;
  logic tlb_clear = 1'b0;
  logic tlb_clearing;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic req_write = 1'b0;
  logic rsp_valid;
  logic [35:0] rsp_pa;
  logic [1:0] rsp_fault;
  logic rsp_abort, irq_pulse;
  logic pt_rd_req;
  logic [35:0] pt_rd_addr;
  logic pt_rd_valid = 1'b0;
  logic [31:0] pt_rd_data = '0;

  int checks = 0, errors = 0, reads = 0, mem_lat = 2;
  logic [35:0] last_addr = '0;
  logic [35:0] g_pa;
  logic [1:0] g_fault;
  logic g_abort, g_irq;
  int g_lat;

  always #4 clk = ~clk;

  flat_mmu u0 (.*);

  function automatic logic [31:0] pte_of(logic [19:0] vpn);
    logic [31:0] h;
    logic [23:0] base;
    logic w;
    h = 32'(vpn[19:8]) * 32'h9E3779B1;
    base = h[31:8] & 24'h7FFFFF;
    w = vpn[10];
    case (vpn[9:8])
      2'd0: return {1'b1, 1'b0, w, 1'b1, 4'h0, base[23:8], vpn[7:0]};
      2'd1: return {1'b0, 1'b1, w, 1'b1, 4'h0, base[23:4], vpn[3:0]};
      2'd2: return {2'b00, 1'b1, 1'b1, 4'h0, base[23:12], vpn[11:0]};
      default: return {2'b00, vpn[2], vpn[1:0] != 2'b00, 4'h0, base[23:12], vpn[11:0]};
    endcase
  endfunction

  function automatic logic [39:0] expect_of(logic [31:0] va, logic wr);
    logic [31:0] p;
    logic [35:0] pa;
    logic [1:0] c;
    logic ab, iq;
    if (!mmu_en) return {4'b0000, 4'h0, va};
    p = pte_of(va[31:12]);
    if (p[31])      pa = {p[23:8], va[19:0]};
    else if (p[30]) pa = {p[23:4], va[15:0]};
    else            pa = {p[23:0], va[11:0]};
    if (!p[28])               c = 2'd1;
    else if (wr && !p[29])    c = 2'd2;
    else if (pa[35:12] >= cap_frames) c = 2'd3;
    else                      c = 2'd0;
    if (c != 2'd0 && scratch_en) pa = {scratch_frame, va[11:0]};
    ab = (c != 2'd0) && fault_policy[2*(int'(c)-1)];
    iq = (c != 2'd0) && fault_policy[2*(int'(c)-1)+1];
    return {ab, iq, c, pa};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] va, input logic wr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 0;
    while (!rsp_valid && g_lat < 200) begin @(negedge clk); g_lat++; end
    g_pa = rsp_pa; g_fault = rsp_fault; g_abort = rsp_abort; g_irq = irq_pulse;
  endtask

  task automatic req_check(input string req, input logic [31:0] va, input logic wr);
    logic [39:0] e;
    e = expect_of(va, wr);
    do_req(va, wr);
    chk(req, {g_abort, g_irq, g_fault, g_pa}, e);
  endtask

  task automatic pulse_clear();
    @(negedge clk); tlb_clear = 1'b1;
    @(negedge clk); tlb_clear = 1'b0;
  endtask

  task automatic wait_clear_done(input string req);
    int n;
    n = 0;
    while (tlb_clearing && n < 50) begin @(negedge clk); n++; end
    chk(req, 64'(n <= 8 + 3), 64'd1);
  endtask

  initial begin : mem
    forever begin
      @(negedge clk);
      if (pt_rd_req) begin
        reads++;
        last_addr = pt_rd_addr;
        repeat (mem_lat) @(negedge clk);
        pt_rd_data = pte_of(20'((pt_rd_addr - {table_frame, 12'h000}) >> 2));
        pt_rd_valid = 1'b1;
        @(negedge clk);
        pt_rd_valid = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int r0;
    logic [11:0] regs [5];
    regs[0] = 12'h004; regs[1] = 12'h105; regs[2] = 12'h206;
    regs[3] = 12'h307; regs[4] = 12'h00C;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {60'd0, rsp_valid, pt_rd_req, tlb_clearing, req_ready}, 64'd1);

    r0 = reads;
    req_check("R2 pass-through", 32'hDEADB123, 1'b0);
    chk("R2 no read, one-cycle answer", {32'(reads - r0), 32'(g_lat)}, 64'd0);

    mmu_en = 1'b1;
    r0 = reads;
    req_check("R4 small page miss", 32'h00205ABC, 1'b1);
    chk("R3 one read", 64'(reads - r0), 64'd1);
    chk("R3 entry address", 64'(last_addr), 64'({24'h012340, 12'h000} + 36'h00205 * 4));
    chk("R3 walk latency", 64'(g_lat > 0), 64'd1);
    r0 = reads;
    req_check("R6 small page hit", 32'h00205111, 1'b0);
    chk("R6 hit no read", {32'(reads - r0), 32'(g_lat)}, 64'd0);

    req_check("R5 big page miss", 32'h00103456, 1'b0);
    r0 = reads;
    req_check("R5 big page region hit", 32'h0010C789, 1'b0);
    chk("R5 big region no read", 64'(reads - r0), 64'd0);
    req_check("R5 super page miss", 32'h00400010, 1'b0);
    r0 = reads;
    req_check("R5 super page region hit", 32'h004F7ABC, 1'b1);
    chk("R5 super region no read", 64'(reads - r0), 64'd0);

    fault_policy = 6'b000001;
    req_check("R7 R8 invalid abort only", 32'h00300123, 1'b0);
    chk("R7 invalid code", 64'(g_fault), 64'd1);
    r0 = reads;
    req_check("R7 invalid not cached", 32'h00300123, 1'b0);
    chk("R7 invalid rewalk", 64'(reads - r0), 64'd1);
    fault_policy = 6'b001000;
    req_check("R7 R8 write violation irq only", 32'h00301000, 1'b1);
    chk("R7 write code", 64'(g_fault), 64'd2);
    fault_policy = 6'b110000;
    cap_frames = 24'h000001;
    req_check("R7 R8 cap exceeded", 32'h00205ABC, 1'b0);
    chk("R7 cap code", 64'(g_fault), 64'd3);
    cap_frames = 24'hFFFFFF;
    scratch_en = 1'b1;
    fault_policy = 6'b000011;
    req_check("R9 scratch redirect", 32'h00300123, 1'b0);
    chk("R9 scratch pa", 64'(g_pa), 64'h0ABCDEF123);
    scratch_en = 1'b0;

    pulse_clear();
    chk("R10 clearing raised", {62'd0, tlb_clearing, req_ready}, 64'd2);
    wait_clear_done("R10 clear finishes");
    r0 = reads;
    req_check("R10 miss after clear", 32'h00205ABC, 1'b0);
    chk("R10 miss after clear read", 64'(reads - r0), 64'd1);

    mem_lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h00206004; req_write = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    tlb_clear = 1'b1; @(negedge clk); tlb_clear = 1'b0;
    chk("R11 clearing during walk", {63'd0, tlb_clearing}, 64'd1);
    g_lat = 0;
    while (!rsp_valid && g_lat < 200) begin @(negedge clk); g_lat++; end
    chk("R11 walk answer", {rsp_abort, irq_pulse, rsp_fault, rsp_pa}, expect_of(32'h00206004, 1'b0));
    wait_clear_done("R11 clear after walk");
    mem_lat = 2;
    r0 = reads;
    req_check("R11 no stale entry", 32'h00206004, 1'b0);
    chk("R11 page misses", 64'(reads - r0), 64'd1);

    pulse_clear();
    wait_clear_done("R12 clear before fill order");
    for (int i = 0; i < 8; i++) req_check("R12 fill", {20'h00210 + 20'(i), 12'h0}, 1'b0);
    r0 = reads;
    for (int i = 0; i < 8; i++) req_check("R12 all resident", {20'h00210 + 20'(i), 12'h4}, 1'b0);
    chk("R12 eight hits", 64'(reads - r0), 64'd0);
    r0 = reads;
    req_check("R12 ninth page", 32'h00218000, 1'b0);
    req_check("R12 first evicted", 32'h00210000, 1'b0);
    chk("R12 two misses", 64'(reads - r0), 64'd2);
    r0 = reads;
    req_check("R12 third still resident", 32'h00212000, 1'b0);
    chk("R12 third hits", 64'(reads - r0), 64'd0);
    req_check("R12 second evicted", 32'h00211000, 1'b0);
    chk("R12 second misses", 64'(reads - r0), 64'd1);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] va;
      va = {regs[$urandom % 5], 8'($urandom), 12'($urandom)};
      fault_policy = 6'($urandom);
      scratch_en = 1'($urandom);
      mem_lat = 1 + ($urandom % 4);
      req_check("R4 R5 R7 R8 R9 random", va, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule